// File: doc/BRIEF.md
# Paged MMU register bank

This block holds the page tables and the two control words of a three-mode paged memory management unit. Each of the kernel, supervisor and user modes owns two sets of eight pages: one set for instruction fetches and one for data. Each page has a 16-bit base register and a 16-bit descriptor register. A status/control word and a mode-enable word sit next to them. A processor reaches every register through a small word-or-byte register port. The read path is combinational. Every write takes effect at the next clock edge.

The block also applies the side effects that go with each update. Descriptor writes clear the reserved bits and the accessed/written flags. A base-register write clears the accessed/written flags of its descriptor. The control words are masked, and the status word has a write-protect rule that depends on whether a fault is latched. A separate strobe from the address translator reports writes to translated memory, and the block then sets the written flag of the descriptor used. The full tables and both control words are exported flat so that a translator can read them without going through the port.

Top module: `mmu_regfile`

## Requirements
- R1: After reset every base register, every descriptor, the status word and the mode-enable word read as zero.
- R2: The port address is 8 bits wide. Bits 7:6 select the mode slot (0 kernel, 1 supervisor, 2 user). Bit 5 selects a base register (1) or a descriptor (0). Bit 4 selects the data set (1) or the instruction set (0). Bits 3:1 select the page. Address 0xC0 is the status word and 0xC2 is the mode-enable word. All other addresses read zero and ignore writes.
- R3: A byte write (data in bits 7:0) to an odd address replaces bits 15:8 of the register and leaves the low byte unchanged. A byte write to an even address replaces bits 7:0. A byte write to the status word does a plain byte replace with no masking.
- R4: A word read returns all 16 bits. A byte read returns the addressed byte in bits 7:0 with zeros above it (odd address gives the high byte). When no read is requested, the read data is zero.
- R5: After any descriptor write, bits 15, 7, 6, 5 and 4 of that descriptor are zero.
- R6: A base-register write clears bits 7 and 6 of the descriptor with the same mode, set and page. The descriptor's other bits are unchanged.
- R7: A translated-write strobe sets bit 6 of the descriptor it names if four conditions hold: the status word's bit 0 is set, the virtual address is even, the address is not the status word's virtual address (parameter, default octal 177572), and the mode code is 0, 1 or 3 (kernel, supervisor, user). Otherwise the strobe has no effect. The descriptor page is taken from virtual address bits 15:13. A port write to the same descriptor in the same cycle takes priority.
- R8: A write to the mode-enable word keeps only the bits in octal mask 067.
- R9: A word write to the status word forces bits 11:10 to zero. If the written value has bit 0 set, bits 15:13 are also cleared.
- R10: If any of the status word's bits 15:13 is set and a word write has bit 0 clear, the stored value is the written value ANDed with 0x00FE.
- R11: The exports show each base register and descriptor at flat index mode_slot*16 + set*8 + page. They update in the cycle after a write, as do the exported control words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register port access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_byte | input | 1 | 1 = byte access, 0 = word access |
| acc_addr | input | 8 | Register byte address |
| acc_wdata | input | 16 | Write data (byte data in bits 7:0) |
| rd_data | output | 16 | Combinational read data |
| mark_valid | input | 1 | Translated memory write strobe |
| mark_mode | input | 2 | Mode code of that write (0,1,3) |
| mark_dspace | input | 1 | Descriptor set used: 1 data, 0 instruction |
| mark_vaddr | input | 16 | Virtual address of that write |
| par_flat | output | 768 | All 48 base registers, flattened |
| pdr_flat | output | 768 | All 48 descriptors, flattened |
| mmr0_o | output | 16 | Status/control word |
| mmr3_o | output | 16 | Mode-enable word |

## Verification
Read data is due in the same cycle as the address, so the bench applies a read after a falling edge and compares it 1 ns later, before the next rising edge. A write or strobe is latched at the single rising edge that follows its application. The bench therefore drops the request at the next falling edge, updates its model, and only then compares reads or exports. A same-cycle port/strobe collision is driven for one edge to check the priority rule of R7.

// File: rtl/mmu_regfile.sv
module mmu_regfile #(
  parameter logic [15:0] MMR0_VADDR = 16'o177572
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_valid,
  input  logic         acc_write,
  input  logic         acc_byte,
  input  logic [7:0]   acc_addr,
  input  logic [15:0]  acc_wdata,
  output logic [15:0]  rd_data,
  input  logic         mark_valid,
  input  logic [1:0]   mark_mode,
  input  logic         mark_dspace,
  input  logic [15:0]  mark_vaddr,
  output logic [767:0] par_flat,
  output logic [767:0] pdr_flat,
  output logic [15:0]  mmr0_o,
  output logic [15:0]  mmr3_o
);
  localparam int NPAGE = 8;
  localparam int NSET  = 2;
  localparam int NSLOT = 3;
  localparam int NREG  = NSLOT * NSET * NPAGE;
  localparam logic [15:0] PDR_ZERO  = 16'h80F0;
  localparam logic [15:0] AW_FLAGS  = 16'h00C0;
  localparam logic [15:0] WR_FLAG   = 16'h0040;
  localparam logic [15:0] MMR3_KEEP = 16'o000067;

  logic [15:0] par_q [NREG];
  logic [15:0] pdr_q [NREG];
  logic [15:0] mmr0_q, mmr3_q;

  wire       in_win = acc_addr[7:6] != 2'd3;
  wire [5:0] bidx   = in_win ? {acc_addr[7:6], acc_addr[4:1]} : 6'd0;
  wire       wr     = acc_valid & acc_write;
  wire       wr_pdr = wr & in_win & ~acc_addr[5];
  wire       wr_par = wr & in_win & acc_addr[5];
  wire       hit_m0 = acc_addr[7:1] == 7'b1100000;
  wire       hit_m3 = acc_addr[7:1] == 7'b1100001;

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d,
                                        input logic b, input logic hi);
    if (!b)      return d;
    else if (hi) return {d[7:0], old[7:0]};
    else         return {old[15:8], d[7:0]};
  endfunction

  logic [15:0] m0_next;
  always_comb begin
    m0_next = acc_wdata & ~16'h0C00;
    if (m0_next[0]) m0_next = m0_next & ~16'hE000;
    if ((mmr0_q[15:13] != 3'd0) && !m0_next[0]) m0_next = m0_next & 16'h00FE;
  end

  wire [1:0] mslot   = (mark_mode == 2'd3) ? 2'd2 : mark_mode;
  wire       mark_ok = mark_valid & mmr0_q[0] & ~mark_vaddr[0] &
                       (mark_vaddr != MMR0_VADDR) & (mark_mode != 2'd2);
  wire [5:0] midx    = {mslot, mark_dspace, mark_vaddr[15:13]};

  wire [15:0] wmerge_pdr = merge(pdr_q[bidx], acc_wdata, acc_byte, acc_addr[0]);
  wire [15:0] wmerge_par = merge(par_q[bidx], acc_wdata, acc_byte, acc_addr[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        par_q[i] <= '0;
        pdr_q[i] <= '0;
      end
      mmr0_q <= '0;
      mmr3_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wr_pdr && bidx == 6'(i))
          pdr_q[i] <= wmerge_pdr & ~PDR_ZERO;
        else if (wr_par && bidx == 6'(i))
          pdr_q[i] <= pdr_q[i] & ~AW_FLAGS;
        else if (mark_ok && midx == 6'(i))
          pdr_q[i] <= pdr_q[i] | WR_FLAG;
        if (wr_par && bidx == 6'(i))
          par_q[i] <= wmerge_par;
      end
      if (wr && hit_m0)
        mmr0_q <= acc_byte ? merge(mmr0_q, acc_wdata, 1'b1, acc_addr[0]) : m0_next;
      if (wr && hit_m3)
        mmr3_q <= merge(mmr3_q, acc_wdata, acc_byte, acc_addr[0]) & MMR3_KEEP;
    end
  end

  logic [15:0] rd_word;
  always_comb begin
    if (in_win)      rd_word = acc_addr[5] ? par_q[bidx] : pdr_q[bidx];
    else if (hit_m0) rd_word = mmr0_q;
    else if (hit_m3) rd_word = mmr3_q;
    else             rd_word = '0;
  end

  assign rd_data = !(acc_valid && !acc_write) ? 16'h0000 :
                   acc_byte ? {8'h00, acc_addr[0] ? rd_word[15:8] : rd_word[7:0]} : rd_word;

  for (genvar g = 0; g < NREG; g++) begin : g_exp
    assign par_flat[g*16 +: 16] = par_q[g];
    assign pdr_flat[g*16 +: 16] = pdr_q[g];
  end
  assign mmr0_o = mmr0_q;
  assign mmr3_o = mmr3_q;

  AST_PDR_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pdr |=> (pdr_flat[$past(bidx)*16 +: 16] & PDR_ZERO) == 16'h0); // R5
  AST_PAR_CLEARS_AW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_par |=> pdr_flat[$past(bidx)*16 + 6 +: 2] == 2'b00); // R6
  AST_MMR3_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_m3) |=> (mmr3_o & ~MMR3_KEEP) == 16'h0); // R8
  AST_MMR0_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_m0 && !acc_byte) |=> mmr0_o[11:10] == 2'b00); // R9
  AST_MARK_SETS_W: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_ok && !wr) |=> pdr_flat[$past(midx)*16 + 6]); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> rd_data == 16'h0); // R4
endmodule

// File: tb/mmu_regfile_bench.sv
module mmu_regfile_bench;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_write = 0, acc_byte = 0;
  logic [7:0] acc_addr = 0;
  logic [15:0] acc_wdata = 0;
  logic [15:0] rd_data;
  logic mark_valid = 0, mark_dspace = 0;
  logic [1:0] mark_mode = 0;
  logic [15:0] mark_vaddr = 0;
  logic [767:0] par_flat, pdr_flat;
  logic [15:0] mmr0_o, mmr3_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] m_par [48];
  logic [15:0] m_pdr [48];
  logic [15:0] m_m0, m_m3;

  always #5 clk = ~clk;

  mmu_regfile u_mmu_regfile (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] bmerge(input logic [15:0] o, input logic [15:0] d, input bit b, input bit hi);
    if (!b) return d;
    return hi ? {d[7:0], o[7:0]} : {o[15:8], d[7:0]};
  endfunction

  function automatic logic [15:0] m_word(input logic [7:0] a);
    int ix;
    ix = a[7:6] * 16 + a[4:1];
    if (a[7:6] != 3) return a[5] ? m_par[ix] : m_pdr[ix];
    if (a[7:1] == 7'h60) return m_m0;
    if (a[7:1] == 7'h61) return m_m3;
    return 16'h0;
  endfunction

  function automatic void m_write(input logic [7:0] a, input logic [15:0] d, input bit b);
    int ix;
    logic [15:0] v;
    ix = a[7:6] * 16 + a[4:1];
    if (a[7:6] != 3) begin
      if (a[5]) begin
        m_par[ix] = bmerge(m_par[ix], d, b, a[0]);
        m_pdr[ix] = m_pdr[ix] & 16'hFF3F;
      end else m_pdr[ix] = bmerge(m_pdr[ix], d, b, a[0]) & 16'h7F0F;
    end else if (a[7:1] == 7'h60) begin
      if (b) m_m0 = bmerge(m_m0, d, 1, a[0]);
      else begin
        v = d & 16'hF3FF;
        if (v[0]) v = v & 16'h1FFF;
        if (m_m0[15:13] != 0 && !v[0]) v = v & 16'h00FE;
        m_m0 = v;
      end
    end else if (a[7:1] == 7'h61) m_m3 = bmerge(m_m3, d, b, a[0]) & 16'o67;
  endfunction

  function automatic void m_mark(input logic [1:0] md, input bit ds, input logic [15:0] va);
    int ix;
    if (!m_m0[0] || va[0] || va == 16'o177572 || md == 2) return;
    ix = (md == 3 ? 2 : md) * 16 + ds * 8 + va[15:13];
    m_pdr[ix] = m_pdr[ix] | 16'h0040;
  endfunction

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d, input bit b);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_byte = b; acc_addr = a; acc_wdata = b ? {8'h0, d[7:0]} : d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
    m_write(a, acc_wdata, b);
  endtask

  task automatic mark(input logic [1:0] md, input bit ds, input logic [15:0] va);
    @(negedge clk);
    mark_valid = 1; mark_mode = md; mark_dspace = ds; mark_vaddr = va;
    @(negedge clk);
    mark_valid = 0;
    m_mark(md, ds, va);
  endtask

  task automatic rd_chk(input logic [7:0] a, input bit b, input string req);
    logic [15:0] w, e;
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_byte = b; acc_addr = a;
    #1;
    w = m_word(a);
    e = b ? {8'h0, a[0] ? w[15:8] : w[7:0]} : w;
    chk(rd_data === e, req, rd_data, e);
    acc_valid = 0;
  endtask

  task automatic exp_chk(input string req);
    bit ok;
    ok = (mmr0_o === m_m0) && (mmr3_o === m_m3);
    for (int i = 0; i < 48; i++)
      if (par_flat[i*16 +: 16] !== m_par[i] || pdr_flat[i*16 +: 16] !== m_pdr[i]) ok = 0;
    chk(ok, req, mmr0_o, m_m0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    void'($urandom(32'd1234));
    for (int i = 0; i < 48; i++) begin m_par[i] = 0; m_pdr[i] = 0; end
    m_m0 = 0; m_m3 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    exp_chk("R1 reset exports");
    rd_chk(8'hC0, 0, "R1 status reset");
    rd_chk(8'h2E, 0, "R1 base reset");
    chk(rd_data === 16'h0, "R4 idle read zero", rd_data, 16'h0);

    bus_wr(8'h9A, 16'hFFFF, 0);
    rd_chk(8'h9A, 0, "R5 pdr zero bits");
    chk(pdr_flat[(2*16+8+5)*16 +: 16] === 16'h7F0F, "R11 R2 pdr index", pdr_flat[(2*16+8+5)*16 +: 16], 16'h7F0F);
    bus_wr(8'h63, 16'h00AB, 1);
    rd_chk(8'h62, 0, "R3 odd byte write");
    rd_chk(8'h63, 1, "R4 byte read high");
    bus_wr(8'h62, 16'h00CD, 1);
    rd_chk(8'h62, 0, "R3 even byte write");
    rd_chk(8'h62, 1, "R4 byte read low");
    bus_wr(8'hC2, 16'hFFFF, 0);
    rd_chk(8'hC2, 0, "R8 mode-enable mask");
    bus_wr(8'hC0, 16'hFFFF, 0);
    chk(mmr0_o === 16'h13FF, "R9 status word write", mmr0_o, 16'h13FF);
    bus_wr(8'h12, 16'h0F00, 0);
    mark(2'd0, 1, 16'h2000);
    chk(pdr_flat[9*16 + 6] === 1'b1, "R7 mark sets flag", {15'h0, pdr_flat[9*16+6]}, 16'h1);
    bus_wr(8'h32, 16'h1234, 0);
    chk(pdr_flat[9*16 +: 16] === 16'h0F00, "R6 base clears flags", pdr_flat[9*16 +: 16], 16'h0F00);
    mark(2'd2, 0, 16'h0000);
    mark(2'd1, 0, 16'h0001);
    mark(2'd0, 0, 16'o177572);
    exp_chk("R7 strobe ignored cases");
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_byte = 0; acc_addr = 8'h12; acc_wdata = 16'h0300;
    mark_valid = 1; mark_mode = 0; mark_dspace = 1; mark_vaddr = 16'h2000;
    @(negedge clk);
    acc_valid = 0; acc_write = 0; mark_valid = 0;
    m_write(8'h12, 16'h0300, 0);
    chk(pdr_flat[9*16 +: 16] === 16'h0300, "R7 port write priority", pdr_flat[9*16 +: 16], 16'h0300);
    bus_wr(8'hC1, 16'h00E0, 1);
    chk(mmr0_o === 16'hE0FF, "R3 status byte write", mmr0_o, 16'hE0FF);
    bus_wr(8'hC0, 16'h0F0E, 0);
    chk(mmr0_o === 16'h000E, "R10 status protect", mmr0_o, 16'h000E);
    bus_wr(8'hC0, 16'h0000, 0);
    mark(2'd3, 0, 16'h4000);
    exp_chk("R7 strobe disabled by status bit0");
    bus_wr(8'hD0, 16'hFFFF, 0);
    rd_chk(8'hD0, 0, "R2 unmapped address");
    exp_chk("R2 unmapped write ignored");

    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom % 10;
      if ($urandom % 4 == 3) a = {6'b110000, 1'($urandom % 2), 1'($urandom % 2)};
      else a = {2'($urandom % 3), 6'($urandom)};
      if (op < 5) bus_wr(a, 16'($urandom), 1'($urandom % 2));
      else if (op < 7) mark(2'($urandom), 1'($urandom), 16'($urandom) & ($urandom % 2 ? 16'hFFFF : 16'hFFFE));
      else rd_chk(a, 1'($urandom % 2), "R2 R4 random read");
      if (op == 0) bus_wr(8'hC0, 16'($urandom) | 16'h0001, 0);
      if (k % 50 == 0) exp_chk("R11 random exports");
    end
    exp_chk("R11 final exports");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule